// File: doc/BRIEF.md
# Vector Loop State Register with Write Legalization

This block keeps the packed state of a vector loop in one 32-bit control register: the largest vector length the loop may use, the vector length in force, the subvector length, and four element positions (source and destination element offsets, and source and destination offsets inside a subvector). Software reads and writes the whole word through a plain register port. It reads the word to save the loop context on a trap and writes it back to resume. It can also write it directly, for example to make the next vector operation skip leading elements.

Every write is made legal before it is stored, and the checks run in a chain. The maximum length is capped at the machine word width. The vector length is then capped at that new maximum. The two element offsets are then held below the new vector length, and the two subvector offsets below the new subvector length. The register belongs to user mode. A mode-gate input blocks writes and blanks reads whenever the hart is not in user mode. Reads always show the stored, legalized fields.

Top module: `vstate_csr`

## Requirements
- R1: Field layout of the 32-bit word: maxvl-1 in bits 5..0, vl-1 in bits 11..6, source offset in 17..12, destination offset in 23..18, subvl-1 in 25..24, source subvector offset in 28..27, destination subvector offset in 30..29.
- R2: After reset, a user-mode read returns 0. That is maxvl = vl = subvl = 1 and every offset 0.
- R3: A write stores maxvl-1 as the smaller of the written value and XLEN-1.
- R4: A write stores vl-1 as the smaller of the written value and the newly stored maxvl-1.
- R5: The source and destination offsets are each stored as the smaller of the written value and the newly stored vl-1.
- R6: subvl-1 is taken from bits 25..24 alone. Bit 26 is ignored on write and reads 0, and no subvl value is refused.
- R7: The two subvector offsets are each stored as the smaller of the written value and the newly stored subvl-1.
- R8: Bit 31 is ignored on write and reads 0.
- R9: A write while user_mode is 0 leaves the stored state unchanged.
- R10: A read while user_mode is 0 returns 0.
- R11: A word that is already legal is stored unchanged, so a saved word written back restores the state exactly.
- R12: A write is stored at the clock edge where wr_en is sampled high. rd_data shows the old value before that edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode | input | 1 | 1 when the hart runs in user mode |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to be legalized and stored |
| rd_data | output | 32 | Stored legalized word, or 0 outside user mode |

## Verification
Fully random words are used because almost every field in them is out of range. These show whether each clamp uses the newly clamped neighbour and not the raw written one. Biased random words with small maxvl and subvl separate the vl-below-maxvl path from the offset-below-vl path. Directed words cover the rest: all ones, a maxvl above the word width, a set bit 26 or 31, and an already-legal save/restore word. They separate the register cap, the ignored bits and the identity case. Writes made with the mode gate low, followed by a user-mode read, show whether the gate blocks the store or only blanks the read.

// File: rtl/vstate_pkg.sv
package vstate_pkg;
  localparam int LEN_W = 6;
  localparam int SUB_W = 2;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [SUB_W-1:0] dsv;
    logic [SUB_W-1:0] ssv;
    logic [SUB_W-1:0] sub;
    logic [LEN_W-1:0] dst;
    logic [LEN_W-1:0] src;
    logic [LEN_W-1:0] vl;
    logic [LEN_W-1:0] mvl;
  } vstate_t;

  function automatic logic [WORD_W-1:0] vs_pack(vstate_t s);
    return {1'b0, s.dsv, s.ssv, 1'b0, s.sub, s.dst, s.src, s.vl, s.mvl};
  endfunction

  function automatic vstate_t vs_unpack(logic [WORD_W-1:0] w);
    vstate_t s;
    s.mvl = w[5:0];
    s.vl  = w[11:6];
    s.src = w[17:12];
    s.dst = w[23:18];
    s.sub = w[25:24];
    s.ssv = w[28:27];
    s.dsv = w[30:29];
    return s;
  endfunction
endpackage

// File: rtl/vs_clamp.sv
module vs_clamp #(
  parameter int W = 6
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] lim,
  output logic [W-1:0] res
);
  always_comb begin
    res = (val > lim) ? lim : val;
  end
endmodule

// File: rtl/vs_legalize.sv
module vs_legalize
  import vstate_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [WORD_W-1:0] raw,
  output vstate_t           legal
);
  localparam int CAP_EFF = (XLEN > (1 << LEN_W)) ? (1 << LEN_W) : ((XLEN < 1) ? 1 : XLEN);
  localparam logic [LEN_W-1:0] MVL_CAP = LEN_W'(CAP_EFF - 1);

  vstate_t in_s;
  logic unused_bits;
  assign in_s = vs_unpack(raw);
  assign unused_bits = ^{raw[31], raw[26]};

  logic [LEN_W-1:0] mvl_c, vl_c;

  // stage 1: maxvl against the word width
  vs_clamp #(.W(LEN_W)) u_mvl (.val(in_s.mvl), .lim(MVL_CAP), .res(mvl_c));
  // stage 2: vl against the new maxvl
  vs_clamp #(.W(LEN_W)) u_vl  (.val(in_s.vl),  .lim(mvl_c),   .res(vl_c));

  // stage 3: element offsets against the new vl
  logic [LEN_W-1:0] eo_in  [2];
  logic [LEN_W-1:0] eo_out [2];
  assign eo_in[0] = in_s.src;
  assign eo_in[1] = in_s.dst;

  // stage 3: subvector offsets against subvl
  logic [SUB_W-1:0] so_in  [2];
  logic [SUB_W-1:0] so_out [2];
  assign so_in[0] = in_s.ssv;
  assign so_in[1] = in_s.dsv;

  for (genvar g = 0; g < 2; g++) begin : g_offs
    vs_clamp #(.W(LEN_W)) u_eo (.val(eo_in[g]), .lim(vl_c),     .res(eo_out[g]));
    vs_clamp #(.W(SUB_W)) u_so (.val(so_in[g]), .lim(in_s.sub), .res(so_out[g]));
  end

  always_comb begin
    legal     = '0;
    legal.mvl = mvl_c;
    legal.vl  = vl_c;
    legal.src = eo_out[0];
    legal.dst = eo_out[1];
    legal.sub = in_s.sub;
    legal.ssv = so_out[0];
    legal.dsv = so_out[1];
  end
endmodule

// File: rtl/vs_store.sv
module vs_store
  import vstate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  vstate_t d,
  output vstate_t q
);
  vstate_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/vstate_csr.sv
module vstate_csr
  import vstate_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CAP_EFF = (XLEN > (1 << LEN_W)) ? (1 << LEN_W) : ((XLEN < 1) ? 1 : XLEN);
  localparam logic [LEN_W-1:0] MVL_CAP = LEN_W'(CAP_EFF - 1);

  vstate_t legal_s, cur_s;
  logic    load;

  assign load = wr_en & user_mode;

  vs_legalize #(.XLEN(XLEN)) u_legal (.raw(wr_data), .legal(legal_s));
  vs_store u_store (.clk(clk), .rst_n(rst_n), .load(load), .d(legal_s), .q(cur_s));

  always_comb begin
    rd_data = '0;
    if (user_mode) rd_data = vs_pack(cur_s);
  end

  a_r3_mvl_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cur_s.mvl <= MVL_CAP);
  a_r4_vl_le_mvl: assert property (@(posedge clk) disable iff (!rst_n)
    cur_s.vl <= cur_s.mvl);
  a_r5_offs_le_vl: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_s.src <= cur_s.vl) && (cur_s.dst <= cur_s.vl));
  a_r7_svoffs_le_subvl: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_s.ssv <= cur_s.sub) && (cur_s.dsv <= cur_s.sub));
  a_r9_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode || !wr_en) |=> $stable(cur_s));
  a_r11_legal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && user_mode && !wr_data[31] && !wr_data[26] &&
     (wr_data[5:0] <= MVL_CAP) && (wr_data[11:6] <= wr_data[5:0]) &&
     (wr_data[17:12] <= wr_data[11:6]) && (wr_data[23:18] <= wr_data[11:6]) &&
     (wr_data[28:27] <= wr_data[25:24]) && (wr_data[30:29] <= wr_data[25:24]))
    |=> (vs_pack(cur_s) == $past(wr_data)));
endmodule

// File: tb/test_vstate_csr.sv
module test_vstate_csr;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN_T = 32;

  logic clk, rst_n, user_mode, wr_en;
  logic [31:0] wr_data, rd_data;
  int total = 0, bad = 0;
  logic [31:0] shadow;

  vstate_csr #(.XLEN(XLEN_T)) i_vstate_csr (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] min6(logic [5:0] a, logic [5:0] b);
    return (a > b) ? b : a;
  endfunction
  function automatic logic [1:0] min2(logic [1:0] a, logic [1:0] b);
    return (a > b) ? b : a;
  endfunction

  function automatic logic [31:0] model(logic [31:0] w);
    logic [5:0] mvl, vl, src, dst;
    logic [1:0] sub, ssv, dsv;
    mvl = min6(w[5:0], 6'(XLEN_T - 1));
    vl  = min6(w[11:6], mvl);
    src = min6(w[17:12], vl);
    dst = min6(w[23:18], vl);
    sub = w[25:24];
    ssv = min2(w[28:27], sub);
    dsv = min2(w[30:29], sub);
    return {1'b0, dsv, ssv, 1'b0, sub, dst, src, vl, mvl};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] d, logic um);
    @(negedge clk);
    user_mode = um;
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    user_mode = 1'b1;
    if (um) shadow = model(d);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; user_mode = 1'b1; wr_en = 1'b0; wr_data = '0; shadow = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset value", rd_data, 32'h0);

    // R1 R11: legal word kept, fields in place
    w = {1'b0, 2'd1, 2'd2, 1'b0, 2'd3, 6'd4, 6'd9, 6'd10, 6'd20};
    do_write(w, 1'b1);
    check("R11 legal word kept", rd_data, w);
    check("R1 vl field 11..6", 32'(rd_data[11:6]), 32'd10);
    check("R1 dsv field 30..29", 32'(rd_data[30:29]), 32'd1);

    // R3: maxvl above XLEN
    do_write(32'd40, 1'b1);
    check("R3 maxvl cap", rd_data, 32'(XLEN_T - 1));

    // R4 R5: vl and offsets against new small maxvl
    w = {1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 6'd63, 6'd63, 6'd20, 6'd5};
    do_write(w, 1'b1);
    check("R4 vl clamped to maxvl", 32'(rd_data[11:6]), 32'd5);
    check("R5 src clamped to vl", 32'(rd_data[17:12]), 32'd5);
    check("R5 dst clamped to vl", 32'(rd_data[23:18]), 32'd5);

    // R6 R7 R8: bit 26/31 ignored, sv offsets clamp
    w = 32'h8000_0000 | (32'd1 << 26) | (32'd1 << 24) | (32'd3 << 27) | (32'd3 << 29);
    do_write(w, 1'b1);
    check("R6 subvl bits, bit26 zero", 32'(rd_data[26:24]), 32'd1);
    check("R7 sv offsets clamped", 32'(rd_data[30:27]), 32'h5);
    check("R8 bit31 zero", 32'(rd_data[31]), 32'd0);
    do_write(32'hFFFF_FFFF, 1'b1);
    check("R3 R6 all ones", rd_data, model(32'hFFFF_FFFF));

    // R9 R10: gated write
    @(negedge clk);
    user_mode = 1'b0;
    #1;
    check("R10 read gated", rd_data, 32'h0);
    do_write(32'h0000_0042, 1'b0);
    check("R9 gated write ignored", rd_data, shadow);

    // R12: old value before edge, new after
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0041;
    #1;
    check("R12 old before edge", rd_data, shadow);
    @(negedge clk);
    wr_en = 1'b0;
    shadow = model(32'h0000_0041);
    check("R12 new after edge", rd_data, shadow);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic um;
      w = $urandom();
      if (i % 3 == 1) w = w & 32'h7B0C_30C7;
      um = ($urandom() % 8) != 0;
      do_write(w, um);
      check(um ? "R3 R4 R5 R7 random" : "R9 random gated", rd_data, shadow);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule